// File: doc/BRIEF.md
# Four-Lane Word Capture and Serializer

This block takes four 16-bit words from one shared parallel bus and sends them out on four serial lines at the same time. A strobe input picks which words are kept. Its falling edges feed a two-deep red capture pipe and its rising edges feed a two-deep green capture pipe. Within each colour, the older word drives lane 1 and the newer word drives lane 2. A rising edge on a separate start input loads all four lanes into shift registers. It then runs a burst of exactly one word length of shift-clock pulses, with the most significant bit first.

All state is clocked by the single system clock. The strobe and start inputs pass through two-flop synchronisers and then edge detection. Serial data changes only on the falling edge of the shift clock, so a receiver can sample on the rising edge. A polarity input chooses between true and inverted serial data. A busy flag covers the whole burst.

Top module: `quad_word_serializer`

## Requirements
- R1: A falling strobe edge captures the bus word into the red pipe, and a rising strobe edge captures it into the green pipe. The bus is sampled in the cycle the synchronised edge is detected.
- R2: Lane mapping is fixed. ser_out[0] carries the older red word, ser_out[1] the older green word, ser_out[2] the newer red word and ser_out[3] the newer green word.
- R3: A synchronised rising edge of start_in while busy is low launches a burst. busy goes high within a few cycles of the input edge.
- R4: A burst has exactly WORD_W shift-clock pulses. Each low phase and each high phase lasts PHASE_CYC system clocks, and the low phase comes first.
- R5: All lanes shift together, most significant bit first. Serial data changes only when the shift clock falls, so it is stable for the whole high phase.
- R6: With polarity_true = 1 the pins carry the data bits. With polarity_true = 0 they carry the inverted bits.
- R7: While busy is low, every pin sits at the idle level, which is the logic-0 data bit after polarity. With all-zero words, every pin holds the idle level for the whole burst.
- R8: Captures during a burst, or in the same cycle as the launch, change only the capture pipes. The running burst sends the words held before that capture, and the next burst sends the new words.
- R9: A start rising edge while busy is high is ignored and launches no second burst.
- R10: busy falls on the same clock edge as the last shift-clock falling edge.
- R11: Synchronous active-high rst clears both capture pipes and all shift registers. It holds the shift clock low and busy low, and leaves every pin at the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_in | input | 1 | Asynchronous capture strobe; falling edge to red, rising edge to green |
| start_in | input | 1 | Asynchronous burst start; rising edge launches |
| polarity_true | input | 1 | 1 for true serial data, 0 for inverted |
| bus_in | input | WORD_W | Shared parallel data bus |
| ser_out | output | 4 | Serial lanes: red 1, green 1, red 2, green 2 |
| sclk_out | output | 1 | Shift clock, low when idle |
| busy | output | 1 | High for the duration of a burst |

## Verification
Two functions can fall in the same clock: a strobe capture updating a pipe stage, and a launch loading the shift registers from that same stage. The bench changes strobe_in and start_in at the same moment, so both pass through identical synchronisers and are detected in the same cycle. It then requires the burst to send the words captured before that edge, and the following burst to send the new word. A strobe edge during a running burst, and a second start edge during a burst, are judged the same way. The burst bits must stay unchanged, and the burst length must be exactly WORD_W pulses.

// File: rtl/qws_pkg.sv
package qws_pkg;
    localparam int LANES     = 4;
    localparam int LANE_RED1 = 0;
    localparam int LANE_GRN1 = 1;
    localparam int LANE_RED2 = 2;
    localparam int LANE_GRN2 = 3;

    // colour index of a capture pipe
    localparam int PIPE_RED  = 0;
    localparam int PIPE_GRN  = 1;
    localparam int PIPES     = 2;

    // pin level for a data bit under the selected polarity
    function automatic logic drive_level(input logic data_bit, input logic true_pol);
        return data_bit ^ ~true_pol;
    endfunction
endpackage

// File: rtl/qws_edge_sync.sv
module qws_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level_o,
    output logic change_o
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              last;
    } sync_state_t;

    sync_state_t state_q, state_d;

    always_comb begin
        state_d      = state_q;
        state_d.pipe = {state_q.pipe[STAGES-2:0], async_in};
        state_d.last = state_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign level_o  = state_q.pipe[STAGES-1];
    assign change_o = state_q.pipe[STAGES-1] ^ state_q.last;
endmodule

// File: rtl/qws_capture_pair.sv
module qws_capture_pair #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] newer_o,
    output logic [WORD_W-1:0] older_o
);
    typedef struct packed {
        logic [WORD_W-1:0] newer;
        logic [WORD_W-1:0] older;
    } cap_state_t;

    cap_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (take) begin
            state_d.older = state_q.newer;
            state_d.newer = word_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign newer_o = state_q.newer;
    assign older_o = state_q.older;
endmodule

// File: rtl/qws_burst_timer.sv
module qws_burst_timer #(
    parameter int BITS      = 16,
    parameter int PHASE_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic launch_req,
    output logic load_o,
    output logic shift_o,
    output logic sclk_o,
    output logic busy_o
);
    localparam int PH_W  = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam int CNT_W = (BITS > 1) ? $clog2(BITS) : 1;
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(PHASE_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BITS - 1);

    typedef struct packed {
        logic             busy;
        logic             sclk;
        logic [PH_W-1:0]  ph;
        logic [CNT_W-1:0] pulses;
    } timer_state_t;

    timer_state_t state_q, state_d;
    logic         load_c, shift_c;

    always_comb begin
        state_d = state_q;
        load_c  = 1'b0;
        shift_c = 1'b0;
        if (!state_q.busy) begin
            if (launch_req) begin
                load_c         = 1'b1;
                state_d.busy   = 1'b1;
                state_d.sclk   = 1'b0;
                state_d.ph     = '0;
                state_d.pulses = '0;
            end
        end else if (state_q.ph == PH_LAST) begin
            state_d.ph   = '0;
            state_d.sclk = ~state_q.sclk;
            if (state_q.sclk) begin
                shift_c        = 1'b1;
                state_d.pulses = state_q.pulses + 1'b1;
                if (state_q.pulses == CNT_LAST) begin
                    state_d.busy   = 1'b0;
                    state_d.pulses = '0;
                end
            end
        end else begin
            state_d.ph = state_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign load_o  = load_c;
    assign shift_o = shift_c;
    assign sclk_o  = state_q.sclk;
    assign busy_o  = state_q.busy;
endmodule

// File: rtl/qws_lane_shifter.sv
module qws_lane_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] word_in,
    output logic              msb_o
);
    typedef struct packed {
        logic [WORD_W-1:0] sr;
    } shifter_state_t;

    shifter_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (load)       state_d.sr = word_in;
        else if (shift) state_d.sr = {state_q.sr[WORD_W-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign msb_o = state_q.sr[WORD_W-1];
endmodule

// File: rtl/quad_word_serializer.sv
module quad_word_serializer
    import qws_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int PHASE_CYC   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_in,
    input  logic              start_in,
    input  logic              polarity_true,
    input  logic [WORD_W-1:0] bus_in,
    output logic [LANES-1:0]  ser_out,
    output logic              sclk_out,
    output logic              busy
);
    logic strobe_lvl, strobe_chg;
    logic start_lvl, start_chg;
    logic load_w, shift_w;
    logic [PIPES-1:0]  take;
    logic [WORD_W-1:0] newer_w [PIPES];
    logic [WORD_W-1:0] older_w [PIPES];
    logic [WORD_W-1:0] lane_word [LANES];
    logic [LANES-1:0]  lane_bit;

    qws_edge_sync #(.STAGES(SYNC_STAGES)) u_strobe_sync (
        .clk(clk), .rst(rst), .async_in(strobe_in),
        .level_o(strobe_lvl), .change_o(strobe_chg)
    );

    qws_edge_sync #(.STAGES(SYNC_STAGES)) u_start_sync (
        .clk(clk), .rst(rst), .async_in(start_in),
        .level_o(start_lvl), .change_o(start_chg)
    );

    // red pipe on falling strobe, green pipe on rising strobe
    assign take[PIPE_RED] = strobe_chg & ~strobe_lvl;
    assign take[PIPE_GRN] = strobe_chg &  strobe_lvl;

    for (genvar g = 0; g < PIPES; g++) begin : g_cap
        qws_capture_pair #(.WORD_W(WORD_W)) u_cap (
            .clk(clk), .rst(rst), .take(take[g]), .word_in(bus_in),
            .newer_o(newer_w[g]), .older_o(older_w[g])
        );
    end

    qws_burst_timer #(.BITS(WORD_W), .PHASE_CYC(PHASE_CYC)) u_timer (
        .clk(clk), .rst(rst), .launch_req(start_chg & start_lvl),
        .load_o(load_w), .shift_o(shift_w), .sclk_o(sclk_out), .busy_o(busy)
    );

    // lanes 0/1 take the older word of each colour, lanes 2/3 the newer
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (l < PIPES) begin : g_old
            assign lane_word[l] = older_w[l % PIPES];
        end else begin : g_new
            assign lane_word[l] = newer_w[l % PIPES];
        end

        qws_lane_shifter #(.WORD_W(WORD_W)) u_shift (
            .clk(clk), .rst(rst), .load(load_w), .shift(shift_w),
            .word_in(lane_word[l]), .msb_o(lane_bit[l])
        );

        assign ser_out[l] = drive_level(lane_bit[l], polarity_true);
    end
endmodule

// File: rtl/qws_checker.sv
module qws_checker #(
    parameter int WORD_W    = 16,
    parameter int PHASE_CYC = 2,
    parameter int LANES     = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             sclk,
    input logic             busy,
    input logic             pol,
    input logic [LANES-1:0] ser
);
    localparam int RC_W = $clog2(WORD_W + 2);
    localparam int HC_W = $clog2(PHASE_CYC + 2);

    logic            sclk_prev_q;
    logic [RC_W-1:0] rise_cnt_q;
    logic [HC_W-1:0] high_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev_q <= 1'b0;
            rise_cnt_q  <= '0;
            high_cnt_q  <= '0;
        end else begin
            sclk_prev_q <= sclk;
            if (sclk && !sclk_prev_q) rise_cnt_q <= rise_cnt_q + 1'b1;
            else if (!busy)           rise_cnt_q <= '0;
            if (sclk) high_cnt_q <= high_cnt_q + 1'b1;
            else      high_cnt_q <= '0;
        end
    end

    // R4
    sclk_in_burst_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |-> busy);

    // R4
    pulse_total_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (rise_cnt_q == RC_W'(WORD_W)));

    // R4
    high_phase_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> (high_cnt_q == HC_W'(PHASE_CYC)));

    // R5
    data_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk) && $stable(pol)) |-> $stable(ser));

    // R7
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ser == {LANES{~pol}}));

    // R10
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $fell(sclk));

    // R11
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !sclk));
endmodule

bind quad_word_serializer qws_checker #(
    .WORD_W(WORD_W), .PHASE_CYC(PHASE_CYC), .LANES(qws_pkg::LANES)
) u_qws_chk (
    .clk(clk), .rst(rst), .sclk(sclk_out), .busy(busy),
    .pol(polarity_true), .ser(ser_out)
);

// File: tb/sim_quad_word_serializer.sv
module sim_quad_word_serializer;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int PH         = 2;
    localparam int NL         = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strobe_in = 1'b0;
    logic          start_in = 1'b0;
    logic          polarity_true = 1'b1;
    logic [W-1:0]  bus_in = '0;
    logic [NL-1:0] ser_out;
    logic          sclk_out;
    logic          busy;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    logic [W-1:0] m_r_new = '0, m_r_old = '0, m_g_new = '0, m_g_old = '0;

    quad_word_serializer #(.WORD_W(W), .PHASE_CYC(PH)) u0 (
        .clk(clk), .rst(rst), .strobe_in(strobe_in), .start_in(start_in),
        .polarity_true(polarity_true), .bus_in(bus_in),
        .ser_out(ser_out), .sclk_out(sclk_out), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic pin_of(input logic [W-1:0] w, input int k, input logic pol);
        return w[W-1-k] ^ ~pol;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // toggles strobe with a new bus word and updates the lane model (R1)
    task automatic put_edge(input logic [W-1:0] w);
        bus_in    = w;
        strobe_in = ~strobe_in;
        if (!strobe_in) begin m_r_old = m_r_new; m_r_new = w; end
        else            begin m_g_old = m_g_new; m_g_new = w; end
    endtask

    task automatic capture(input logic [W-1:0] w);
        @(negedge clk);
        put_edge(w);
        step(5);
    endtask

    task automatic run_burst(input logic pol, input int again_at, input int cap_at,
                             input logic [W-1:0] cap_word, input bit coincide,
                             input logic [W-1:0] coin_word, input bit zero_watch);
        logic [W-1:0] lanes [NL];
        int t, busy_cyc, pulses;
        logic prev_s;
        // R2 lane order: red older, green older, red newer, green newer
        lanes[0] = m_r_old; lanes[1] = m_g_old; lanes[2] = m_r_new; lanes[3] = m_g_new;
        @(negedge clk);
        polarity_true = pol;
        start_in = 1'b1;
        if (coincide) put_edge(coin_word);   // R8 same-cycle capture and launch
        t = 0;
        while (!busy && t < 20) begin step(1); t++; end
        chk(busy === 1'b1, "R3", "busy after start", int'(busy), 1);
        busy_cyc = 0; pulses = 0; prev_s = 1'b0;
        while (busy && busy_cyc < 1000) begin
            if (sclk_out && !prev_s) begin
                for (int l = 0; l < NL; l++)
                    if (pulses < W)
                        chk(ser_out[l] === pin_of(lanes[l], pulses, pol), "R2 R5 R6",
                            $sformatf("lane %0d bit %0d", l, pulses),
                            int'(ser_out[l]), int'(pin_of(lanes[l], pulses, pol)));
                pulses++;
            end
            if (zero_watch)
                chk(ser_out === {NL{~pol}}, "R7", "zero word pin level",
                    int'(ser_out), int'({NL{~pol}}));
            prev_s = sclk_out;
            busy_cyc++;
            if (busy_cyc == 2) start_in = 1'b0;
            if (busy_cyc == again_at) start_in = 1'b1;       // R9
            if (busy_cyc == again_at + 3) start_in = 1'b0;
            if (busy_cyc == cap_at) put_edge(cap_word);      // R8
            step(1);
        end
        chk(pulses == W, "R4", "shift clock pulses", pulses, W);
        chk(busy_cyc == 2 * PH * W, "R4 R10", "busy length", busy_cyc, 2 * PH * W);
        chk(sclk_out === 1'b0, "R10", "sclk after burst", int'(sclk_out), 0);
        chk(ser_out === {NL{~pol}}, "R7", "idle after burst", int'(ser_out), int'({NL{~pol}}));
        t = 0;
        for (int i = 0; i < 12; i++) begin
            if (busy) t++;
            step(1);
        end
        chk(t == 0, "R9", "no second burst", t, 0);
    endtask

    initial begin
        void'($urandom(32'd7151));
        step(3);
        rst = 1'b0;
        step(1);
        // R11 reset state
        chk(busy === 1'b0, "R11", "busy after reset", int'(busy), 0);
        chk(sclk_out === 1'b0, "R11", "sclk after reset", int'(sclk_out), 0);
        chk(ser_out === 4'b0000, "R11", "pins after reset", int'(ser_out), 0);

        // R1 R2 directed: distinct words per lane
        capture(16'hA5C3);   // rising -> green
        capture(16'h8001);   // falling -> red
        capture(16'h1234);   // rising -> green
        capture(16'hFFFE);   // falling -> red
        run_burst(1'b1, -1, -1, '0, 1'b0, '0, 1'b0);

        // R6 inverted polarity, R9 restart while busy, R8 capture mid-burst
        run_burst(1'b0, 20, 30, 16'h0F0F, 1'b0, '0, 1'b0);
        run_burst(1'b1, -1, -1, '0, 1'b0, '0, 1'b0);

        // R8 capture in the same cycle as launch
        run_burst(1'b1, -1, -1, '0, 1'b1, 16'h7E81, 1'b0);
        run_burst(1'b0, -1, -1, '0, 1'b0, '0, 1'b0);

        // R11 reset in the middle of a burst
        @(negedge clk);
        start_in = 1'b1;
        step(12);
        rst = 1'b1;
        start_in = 1'b0;
        strobe_in = 1'b0;
        step(2);
        rst = 1'b0;
        step(1);
        m_r_new = '0; m_r_old = '0; m_g_new = '0; m_g_old = '0;
        chk(busy === 1'b0, "R11", "busy after mid reset", int'(busy), 0);
        chk(sclk_out === 1'b0, "R11", "sclk after mid reset", int'(sclk_out), 0);
        // R7 R11 cleared words give an idle burst under inverted polarity
        run_burst(1'b0, -1, -1, '0, 1'b0, '0, 1'b1);
        run_burst(1'b1, -1, -1, '0, 1'b0, '0, 1'b1);

        // constrained random words and polarity
        for (int it = 0; it < 8; it++) begin
            for (int e = 0; e < 4; e++) capture(W'($urandom));
            run_burst(1'($urandom), ($urandom % 2) ? 10 + int'($urandom % 40) : -1,
                      ($urandom % 2) ? 5 + int'($urandom % 50) : -1, W'($urandom),
                      1'($urandom), W'($urandom), 1'b0);
        end

        summary();
        $finish;
    end
endmodule